// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a down-counting watchdog driven through a small set of memory-mapped words. Software loads a reload value and turns the counter on in the control word. From then on it must keep writing one fixed 16-bit key to the restart word so that the counter never reaches zero. A restart write that carries any other value does nothing at all. This protects the watchdog against a runaway program that writes into its address range at random.

The counter steps either on every clock cycle or only on cycles where an external 1 MHz tick-enable is high. A control bit picks the source. When a step arrives while the count is already zero, the block expires. It emits a one-cycle timeout event, and the count starts again from the reload value. An interrupt request, a reset request and an external-signal request go out together with that event, each one only if its enable bit is set. The reset-type field and the secondary-boot select are brought out as plain outputs, so that the reset distribution logic can act on them. Tick generation, reset distribution and pulse shaping sit outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: The word at byte offset 0x0 reads the live count, 0x4 reads the reload value, 0x8 always reads zero, and 0xC reads the control byte in bits 7:0 with bits 31:8 zero.
- R2: A write to 0x8 whose bits 15:0 equal 0x4755 loads the reload value into the counter on that clock edge. Bits 31:16 of the write are not looked at.
- R3: A write to 0x8 whose bits 15:0 differ from 0x4755 leaves the count unchanged.
- R4: While control bit 0 is set, the count decreases by one on each step. While bit 0 is clear, the count holds.
- R5: With control bit 4 set, a step occurs only on cycles where tick_1m is high. With bit 4 clear, every clock cycle is a step.
- R6: A step taken while the count is zero and bit 0 is set reloads the count and drives timeout_pulse high for the following cycle.
- R7: irq_req, rst_req and ext_req are high only together with timeout_pulse, and only when control bit 2, bit 1 or bit 3 respectively is set.
- R8: reset_kind follows control bits 6:5 (0 = SoC reset, 1 = full-chip reset), and alt_boot follows control bit 7.
- R9: Writes to 0x0 are ignored. A write to 0x4 changes the reload value but not the count, and it is accepted while the counter is stopped.
- R10: After reset, the control byte is zero, the reload value and the count are all ones, and every event output is low.
- R11: When a key write and a step fall in the same cycle, the key load wins and the count equals the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | 1 MHz tick enable, one clock cycle wide |
| bus_wr | input | 1 | Write strobe; the write happens at the rising clock edge |
| bus_addr | input | 4 | Byte address of the word (must be word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| timeout_pulse | output | 1 | One-cycle expiry event |
| irq_req | output | 1 | Interrupt request that goes with an expiry |
| rst_req | output | 1 | Reset request that goes with an expiry |
| ext_req | output | 1 | External-signal request that goes with an expiry |
| reset_kind | output | 2 | Selected reset type |
| alt_boot | output | 1 | Secondary boot image select |

## Verification
The assertions check on every cycle the step arithmetic of the counter, the key load, the hold while stopped, and that each request only appears beside a timeout event caused by a real expiry. The bench scenarios are what show the system-level facts. These are that non-key and status writes leave the count alone, that the tick selection changes the rate seen over a window, that the key wins over a step in the same cycle, and that the request gating follows the enable bits over many expiries.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

   // Control byte, most significant field first.
   typedef struct packed {
      logic       alt_boot;
      logic [1:0] rst_kind;
      logic       tick_sel;
      logic       ext_en;
      logic       irq_en;
      logic       rst_en;
      logic       run;
   } wdt_ctrl_t;

   localparam int CTRL_W = $bits(wdt_ctrl_t);

   // Word slots decoded from address bits 3:2.
   typedef enum logic [1:0] {
      SLOT_COUNT  = 2'd0,
      SLOT_RELOAD = 2'd1,
      SLOT_KICK   = 2'd2,
      SLOT_CTRL   = 2'd3
   } wdt_slot_e;

endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
   import keyed_wdt_pkg::*;
#(
   parameter int              DATA_W = 32,
   parameter int              ADDR_W = 4,
   parameter int              CNT_W  = 32,
   parameter int              KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY   = 16'h4755
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  reload,
   output wdt_ctrl_t         ctrl,
   output logic              kick,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int SLOT_LSB = 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("keyed_wdt_regs: ADDR_W must be at least 4");
   end
   if (KEY_W > DATA_W || KEY_W < 1) begin : g_bad_key
      $error("keyed_wdt_regs: KEY_W must lie in 1..DATA_W");
   end
   if (CNT_W > DATA_W || CTRL_W > DATA_W) begin : g_bad_width
      $error("keyed_wdt_regs: count and control must fit a data word");
   end

   logic      upper_clear;
   logic      aligned;
   logic      wr_hit;
   wdt_slot_e slot;

   if (ADDR_W > 4) begin : g_wide_addr
      assign upper_clear = (bus_addr[ADDR_W-1:4] == '0);
   end else begin : g_narrow_addr
      assign upper_clear = 1'b1;
   end

   assign aligned = (bus_addr[SLOT_LSB-1:0] == '0);
   assign slot    = wdt_slot_e'(bus_addr[SLOT_LSB+1:SLOT_LSB]);
   assign wr_hit  = bus_wr & upper_clear & aligned;
   assign kick    = wr_hit && (slot == SLOT_KICK) && (bus_wdata[KEY_W-1:0] == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= '1;
      end else if (wr_hit && slot == SLOT_RELOAD) begin
         reload <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_hit && slot == SLOT_CTRL) begin
         ctrl <= wdt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (upper_clear && aligned) begin
         case (slot)
            SLOT_COUNT:  bus_rdata[CNT_W-1:0]  = count;
            SLOT_RELOAD: bus_rdata[CNT_W-1:0]  = reload;
            SLOT_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl;
            default:     bus_rdata = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   // R9: the reload value only moves on a write aimed at its own word
   assert_reload_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(4)) |=> reload == $past(reload));

   // R1: the control byte only moves on a write aimed at its own word
   assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(12)) |=> ctrl == $past(ctrl));

endmodule

// File: rtl/keyed_wdt_tick.sv
module keyed_wdt_tick #(
   parameter bit HAS_FAST = 1'b1
) (
   input  logic tick_1m,
   input  logic sel_slow,
   output logic step
);

   if (HAS_FAST) begin : g_two_sources
      assign step = sel_slow ? tick_1m : 1'b1;
   end else begin : g_slow_only
      logic unused_sel;
      assign unused_sel = sel_slow;
      assign step       = tick_1m;
   end

endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic             kick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("keyed_wdt_counter: CNT_W must be at least 2");
   end

   logic at_zero;
   assign at_zero = (count == '0);
   assign expire  = run & step & ~kick & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '1;
      end else if (kick) begin
         count <= reload;
      end else if (run && step) begin
         count <= at_zero ? reload : count - 1'b1;
      end
   end

   // R2 and R11: a key write always lands the reload value
   assert_key_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> count == $past(reload));

   // R4: one step takes exactly one off a non-zero count
   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && !kick && count != '0) |=> count == $past(count) - 1'b1);

   // R4: a stopped counter without a key write holds its value
   assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !kick) |=> $stable(count));

endmodule

// File: rtl/keyed_wdt_events.sv
module keyed_wdt_events
   import keyed_wdt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire,
   input  wdt_ctrl_t ctrl,
   output logic      timeout_pulse,
   output logic      irq_req,
   output logic      rst_req,
   output logic      ext_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout_pulse <= 1'b0;
         irq_req       <= 1'b0;
         rst_req       <= 1'b0;
         ext_req       <= 1'b0;
      end else begin
         timeout_pulse <= expire;
         irq_req       <= expire & ctrl.irq_en;
         rst_req       <= expire & ctrl.rst_en;
         ext_req       <= expire & ctrl.ext_en;
      end
   end

   // R6: every timeout event comes from an expiry one cycle earlier
   assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> $past(expire));

   // R7: requests only appear beside a timeout event
   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> timeout_pulse);
   assert_rst_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> timeout_pulse);
   assert_ext_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> timeout_pulse);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import keyed_wdt_pkg::*;
#(
   parameter int               DATA_W   = 32,
   parameter int               ADDR_W   = 4,
   parameter int               CNT_W    = 32,
   parameter int               KEY_W    = 16,
   parameter logic [KEY_W-1:0] KEY      = 16'h4755,
   parameter bit               HAS_FAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1m,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              timeout_pulse,
   output logic              irq_req,
   output logic              rst_req,
   output logic              ext_req,
   output logic [1:0]        reset_kind,
   output logic              alt_boot
);

   wdt_ctrl_t        ctrl;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] reload;
   logic             kick;
   logic             step;
   logic             expire;

   keyed_wdt_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .count(count), .reload(reload), .ctrl(ctrl),
      .kick(kick), .bus_rdata(bus_rdata)
   );

   keyed_wdt_tick #(.HAS_FAST(HAS_FAST)) u_tick (
      .tick_1m(tick_1m), .sel_slow(ctrl.tick_sel), .step(step)
   );

   keyed_wdt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .step(step), .kick(kick),
      .reload(reload), .count(count), .expire(expire)
   );

   keyed_wdt_events u_events (
      .clk(clk), .rst_n(rst_n), .expire(expire), .ctrl(ctrl),
      .timeout_pulse(timeout_pulse), .irq_req(irq_req), .rst_req(rst_req),
      .ext_req(ext_req)
   );

   assign reset_kind = ctrl.rst_kind;
   assign alt_boot   = ctrl.alt_boot;

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1m = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        timeout_pulse, irq_req, rst_req, ext_req, alt_boot;
   logic [1:0]  reset_kind;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit slow_mode = 1'b0;
   int div = 0;
   bit model_live = 1'b0;

   // event tallies
   int n_pulse = 0, n_irq = 0, n_rst = 0, n_ext = 0;

   // behavioural reference state
   logic [31:0] m_cnt, m_reload;
   logic [7:0]  m_ctrl;
   bit          m_pulse, m_irq, m_rst, m_ext;

   always #2.5 clk = ~clk;

   keyed_watchdog uut (
      .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timeout_pulse(timeout_pulse), .irq_req(irq_req), .rst_req(rst_req),
      .ext_req(ext_req), .reset_kind(reset_kind), .alt_boot(alt_boot)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // periodic 1 MHz stand-in: one cycle in three when enabled
   always @(negedge clk) begin
      if (slow_mode) begin
         div = (div == 2) ? 0 : div + 1;
         tick_1m = (div == 2);
      end else begin
         div = 0;
         tick_1m = 1'b0;
      end
   end

   // reference model, updated at each rising edge
   always @(posedge clk) begin
      bit step, key, np;
      if (!rst_n) begin
         m_cnt = '1; m_reload = '1; m_ctrl = '0;
         m_pulse = 0; m_irq = 0; m_rst = 0; m_ext = 0;
         model_live = 1'b1;
      end else begin
         step = m_ctrl[4] ? tick_1m : 1'b1;
         key  = bus_wr && bus_addr == 4'h8 && bus_wdata[15:0] == 16'h4755;
         np   = 0;
         if (key) m_cnt = m_reload;
         else if (m_ctrl[0] && step) begin
            if (m_cnt == 0) begin m_cnt = m_reload; np = 1; end
            else m_cnt = m_cnt - 1;
         end
         m_pulse = np; m_irq = np && m_ctrl[2];
         m_rst = np && m_ctrl[1]; m_ext = np && m_ctrl[3];
         if (bus_wr && bus_addr == 4'h4) m_reload = bus_wdata;
         if (bus_wr && bus_addr == 4'hC) m_ctrl = bus_wdata[7:0];
      end
   end

   // compare on every clock, shortly after the edge
   always @(posedge clk) begin
      logic [31:0] exp_rd;
      #1;
      if (rst_n && model_live) begin
         case (bus_addr)
            4'h0: exp_rd = m_cnt;
            4'h4: exp_rd = m_reload;
            4'hC: exp_rd = {24'h0, m_ctrl};
            default: exp_rd = 32'h0;
         endcase
         chk("R1/R4 model rdata", bus_rdata, exp_rd);
         chk("R6 model pulse", {31'h0, timeout_pulse}, {31'h0, m_pulse});
         chk("R7 model requests", {29'h0, irq_req, rst_req, ext_req},
             {29'h0, m_irq, m_rst, m_ext});
         chk("R8 model kind", {29'h0, alt_boot, reset_kind},
             {29'h0, m_ctrl[7], m_ctrl[6:5]});
         n_pulse += timeout_pulse; n_irq += irq_req;
         n_rst += rst_req; n_ext += ext_req;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=%0d expected=<60000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] d, d2;
      int p0, i0, r0, e0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(4'h0, d); chk("R10 count after reset", d, 32'hFFFF_FFFF);
      rd(4'h4, d); chk("R10 reload after reset", d, 32'hFFFF_FFFF);
      rd(4'hC, d); chk("R10 control after reset", d, 32'h0);
      chk("R10 outputs after reset",
          {26'h0, timeout_pulse, irq_req, rst_req, ext_req, reset_kind[0], alt_boot}, 32'h0);
      rd(4'h8, d); chk("R1 restart word reads zero", d, 32'h0);

      // R9 reload write while stopped
      wr(4'h4, 32'd5);
      rd(4'h0, d); chk("R9 reload write leaves count", d, 32'hFFFF_FFFF);
      rd(4'h4, d); chk("R1 reload readback", d, 32'd5);

      // R3 non-key restart writes
      wr(4'h8, 32'h0000_1234);
      rd(4'h0, d); chk("R3 wrong key ignored", d, 32'hFFFF_FFFF);
      wr(4'h8, 32'h4755_0000);
      rd(4'h0, d); chk("R3 key in upper half ignored", d, 32'hFFFF_FFFF);

      // R2 key with arbitrary upper bits
      wr(4'h8, 32'hFFFF_4755);
      rd(4'h0, d); chk("R2 key loads reload", d, 32'd5);

      // R9 status write ignored
      wr(4'h0, 32'h77);
      rd(4'h0, d); chk("R9 status write ignored", d, 32'd5);

      // R1 / R8 control fields
      wr(4'hC, 32'hFFFF_FFE0);
      rd(4'hC, d); chk("R1 control upper bits zero", d, 32'hE0);
      chk("R8 reset_kind", {30'h0, reset_kind}, 32'd3);
      chk("R8 alt_boot", {31'h0, alt_boot}, 32'd1);
      rd(4'h0, d); chk("R4 stopped count holds", d, 32'd5);
      wr(4'hC, 32'h20);
      chk("R8 full-chip kind", {30'h0, reset_kind}, 32'd1);

      // R6 / R7 fast stepping with interrupt only
      p0 = n_pulse; i0 = n_irq; r0 = n_rst; e0 = n_ext;
      wr(4'hC, 32'h05);
      repeat (60) @(negedge clk);
      wr(4'hC, 32'h00);
      chk("R6 fast expiry count in range",
          {31'h0, (n_pulse - p0 >= 9) && (n_pulse - p0 <= 11)}, 32'd1);
      chk("R7 irq with every pulse", n_irq - i0, n_pulse - p0);
      chk("R7 rst gated off", n_rst - r0, 0);
      chk("R7 ext gated off", n_ext - e0, 0);

      // R4 hold after stop
      rd(4'h0, d);
      repeat (10) @(negedge clk);
      rd(4'h0, d2); chk("R4 count stable while stopped", d2, d);

      // R5 slow stepping on tick_1m
      slow_mode = 1'b1;
      wr(4'h4, 32'd20);
      wr(4'hC, 32'h1B);
      wr(4'h8, 32'h4755);
      repeat (30) @(posedge clk);
      rd(4'h0, d); chk("R5 ten ticks in thirty cycles", d, 32'd10);

      p0 = n_pulse; i0 = n_irq; r0 = n_rst; e0 = n_ext;
      repeat (200) @(negedge clk);
      chk("R6 slow expiries seen", {31'h0, (n_pulse - p0) >= 2}, 32'd1);
      chk("R7 rst with every pulse", n_rst - r0, n_pulse - p0);
      chk("R7 ext with every pulse", n_ext - e0, n_pulse - p0);
      chk("R7 irq gated off", n_irq - i0, 0);
      wr(4'hC, 32'h00);
      slow_mode = 1'b0;

      // R11 key write beats a same-cycle step
      wr(4'h4, 32'd9);
      wr(4'hC, 32'h01);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h4755;
      repeat (5) @(negedge clk);
      bus_wr = 1'b0; bus_addr = 4'h0;
      #1;
      chk("R11 key wins over step", bus_rdata, 32'd9);
      wr(4'hC, 32'h00);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule